// File: doc/BRIEF.md
# Serial Transmit Holding Register and Output Shifter

This block is the transmit data path of one channel of a synchronous serial port. Software writes words into a 32-bit holding register, or a DMA engine does. The holding register feeds an output shift register, so together they queue up to two words. When the shifter has no word and the holding register is full, the word moves across on its own. The shifter then waits for a frame start and sends the word most significant bit first, one bit for each serial-clock strobe.

The word length can be set from 3 to 32 bits. Shorter words are right-justified in the 32-bit register, so only their low bits are sent. A one-cycle interrupt fires each time the shifter takes a word, which means the holding register can accept another. The interrupt is held back in DMA mode and while the mask input is high. A sticky underflow flag records a frame start that found nothing to send. The serial clock arrives as a clock-enable strobe in the system clock domain. Frame-sync generation and clock division belong to neighbouring blocks.

Top module: `sertx_chan`

## Requirements
- R1: After a synchronous active-high reset, `full`, `underflow`, `tx_active`, `tx_irq` and `txd` are all 0. This holds even if a word was in flight.
- R2: When `dma_en`=0, a `cpu_wr` pulse while the holding register is empty stores `wdata` and sets `full` at the next edge, and `dma_wr` is ignored. When `dma_en`=1 only `dma_wr` is accepted, and `cpu_wr` is ignored.
- R3: A write while `full`=1 is ignored and leaves the held word unchanged. `full` stays high until the word moves to the shifter, so at most two words are pending.
- R4: When the holding register is full and the shifter holds no word, the word moves to the shifter at the next edge, and `full` falls after that edge.
- R5: `tx_irq` is a one-cycle pulse seen after the same edge that clears `full` on a transfer. No pulse occurs if `dma_en` or `irq_mask` was high in the transfer cycle.
- R6: A word in the shifter waits for a cycle with `sclk_en`=1 and `frame_start`=1. After that edge `tx_active`=1 and `txd` shows bit L-1 of the word. Each later `sclk_en` edge moves `txd` to the next lower bit. The `sclk_en` edge after the one that presented bit 0 drops `tx_active`. A `frame_start` seen while `tx_active`=1 has no effect.
- R7: `slen` holds the word length minus one and is captured when the word moves to the shifter. The values 0 and 1 are treated as 2, giving 3 bits. Bits of the word above the length are never sent.
- R8: `underflow` is set by a cycle with `sclk_en`=1 and `frame_start`=1 while the holding register is empty and the shifter holds no word. It stays set until an edge with `uf_clr`=1. If a set and a clear fall on the same edge, the set wins.
- R9: `dma_req` is high exactly when `dma_en`=1 and `full`=0.
- R10: `txd` is 0 whenever `tx_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_en | input | 1 | Serial bit strobe, one cycle per bit |
| frame_start | input | 1 | Frame start, qualified by `sclk_en` |
| slen | input | 5 | Word length minus one |
| dma_en | input | 1 | Selects DMA as the write source and masks the interrupt |
| cpu_wr | input | 1 | Processor write strobe |
| dma_wr | input | 1 | DMA write strobe |
| wdata | input | 32 | Write data, right-justified |
| irq_mask | input | 1 | Interrupt mask |
| uf_clr | input | 1 | Write-one-to-clear for underflow |
| txd | output | 1 | Serial data out |
| tx_active | output | 1 | A word is being shifted |
| full | output | 1 | Holding register holds an unsent word |
| dma_req | output | 1 | DMA request for the next word |
| tx_irq | output | 1 | Ready interrupt pulse |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The bench fills both queue positions and then writes a third word while full. A design that dropped the full check would overwrite the pending word, and a later frame would then carry the wrong word or skip the underflow. Lengths of 32 bits, 3 bits and the clamped code 0 are sent with junk in the unused upper bits. A design that sent from bit 31 or mishandled the clamp would put wrong bits into the scoreboard stream. The bench also covers the DMA and mask cases, where a design that ignored either would produce an extra interrupt pulse. It also checks a clear of underflow on the same edge as a new set, a frame start arriving mid-word, and a reset during shifting.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic [1:0] {
      SH_IDLE   = 2'd0,
      SH_ARMED  = 2'd1,
      SH_ACTIVE = 2'd2
   } sh_state_e;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          dma_en,
   input  logic          cpu_wr,
   input  logic          dma_wr,
   input  logic [DW-1:0] wdata,
   input  logic          take,
   output logic          full,
   output logic [DW-1:0] data
);
   logic accept;

   // source select: the DMA strobe owns the register in DMA mode
   assign accept = dma_en ? dma_wr : cpu_wr;

   always_ff @(posedge clk) begin
      if (rst) begin
         full <= 1'b0;
         data <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (!full && accept) begin
         full <= 1'b1;
         data <= wdata;
      end
   end

   // R3: a pending word is neither lost nor overwritten until taken
   a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
      (full && !take) |=> (full && $stable(data)));
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int DW      = 32,
   parameter int MIN_LEN = 3,
   localparam int LW     = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bit_en,
   input  logic          frame_start,
   input  logic          ld,
   input  logic [DW-1:0] ld_word,
   input  logic [LW-1:0] ld_len,
   output logic          idle,
   output logic          active,
   output logic          txd
);
   localparam logic [LW-1:0] LEN_LO = LW'(MIN_LEN - 1);
   localparam logic [LW-1:0] LEN_HI = LW'(DW - 1);

   sh_state_e     st;
   logic [DW-1:0] word_q;
   logic [LW-1:0] len_q;
   logic [LW-1:0] idx;
   logic [LW-1:0] len_fix;

   always_comb begin
      if (ld_len < LEN_LO)      len_fix = LEN_LO;
      else if (ld_len > LEN_HI) len_fix = LEN_HI;
      else                      len_fix = ld_len;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= SH_IDLE;
         word_q <= '0;
         len_q  <= '0;
         idx    <= '0;
      end else begin
         case (st)
            SH_IDLE: if (ld) begin
               word_q <= ld_word;
               len_q  <= len_fix;
               st     <= SH_ARMED;
            end
            SH_ARMED: if (bit_en && frame_start) begin
               idx <= len_q;
               st  <= SH_ACTIVE;
            end
            SH_ACTIVE: if (bit_en) begin
               if (idx == '0) st  <= SH_IDLE;
               else           idx <= idx - 1'b1;
            end
            default: st <= SH_IDLE;
         endcase
      end
   end

   assign idle   = (st == SH_IDLE);
   assign active = (st == SH_ACTIVE);
   assign txd    = active ? word_q[idx] : 1'b0;

   // R6: every strobe inside a word steps exactly one bit lower
   a_r6_step_down: assert property (@(posedge clk) disable iff (rst)
      (st == SH_ACTIVE && bit_en && idx != '0) |=>
      (st == SH_ACTIVE && idx == $past(idx) - 1'b1));
   // R6: an armed word does not start without a qualified frame start
   a_r6_wait_frame: assert property (@(posedge clk) disable iff (rst)
      (st == SH_ARMED && !(bit_en && frame_start)) |=> (st == SH_ARMED));
   // R7: captured length always lies inside the legal range
   a_r7_len_range: assert property (@(posedge clk) disable iff (rst)
      (st != SH_IDLE) |-> (len_q >= LEN_LO && len_q <= LEN_HI));
endmodule

// File: rtl/sertx_flags.sv
module sertx_flags (
   input  logic clk,
   input  logic rst,
   input  logic ld,
   input  logic dma_en,
   input  logic irq_mask,
   input  logic uf_set,
   input  logic uf_clr,
   output logic irq,
   output logic uf
);
   always_ff @(posedge clk) begin
      if (rst) begin
         irq <= 1'b0;
         uf  <= 1'b0;
      end else begin
         irq <= ld & ~dma_en & ~irq_mask;
         if (uf_set)      uf <= 1'b1;
         else if (uf_clr) uf <= 1'b0;
      end
   end

   // R8: the flag is sticky without a clear
   a_r8_uf_sticky: assert property (@(posedge clk) disable iff (rst)
      (uf && !uf_clr) |=> uf);
   // R8: the flag only rises after a set request
   a_r8_uf_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(uf) |-> $past(uf_set));
endmodule

// File: rtl/sertx_chan.sv
module sertx_chan #(
   parameter int DW      = 32,
   parameter int MIN_LEN = 3,
   localparam int LW     = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          sclk_en,
   input  logic          frame_start,
   input  logic [LW-1:0] slen,
   input  logic          dma_en,
   input  logic          cpu_wr,
   input  logic          dma_wr,
   input  logic [DW-1:0] wdata,
   input  logic          irq_mask,
   input  logic          uf_clr,
   output logic          txd,
   output logic          tx_active,
   output logic          full,
   output logic          dma_req,
   output logic          tx_irq,
   output logic          underflow
);
   generate
      if (MIN_LEN < 2) begin : g_bad_min
         $error("sertx_chan: MIN_LEN must be at least 2");
      end
      if (DW < MIN_LEN || DW < 4) begin : g_bad_dw
         $error("sertx_chan: DW too small for MIN_LEN");
      end
   endgenerate

   logic          sh_idle;
   logic          ld;
   logic [DW-1:0] hold_data;

   assign ld      = full & sh_idle;
   assign dma_req = dma_en & ~full;

   sertx_hold #(.DW(DW)) u_hold (
      .clk(clk), .rst(rst), .dma_en(dma_en), .cpu_wr(cpu_wr),
      .dma_wr(dma_wr), .wdata(wdata), .take(ld),
      .full(full), .data(hold_data)
   );

   sertx_shifter #(.DW(DW), .MIN_LEN(MIN_LEN)) u_shift (
      .clk(clk), .rst(rst), .bit_en(sclk_en), .frame_start(frame_start),
      .ld(ld), .ld_word(hold_data), .ld_len(slen),
      .idle(sh_idle), .active(tx_active), .txd(txd)
   );

   sertx_flags u_flags (
      .clk(clk), .rst(rst), .ld(ld), .dma_en(dma_en), .irq_mask(irq_mask),
      .uf_set(sclk_en & frame_start & sh_idle & ~full),
      .uf_clr(uf_clr), .irq(tx_irq), .uf(underflow)
   );

   // R5: a pulse follows a transfer, seen as full just dropping
   a_r5_irq_on_load: assert property (@(posedge clk) disable iff (rst)
      tx_irq |-> (!full && $past(full)));
   // R5: no pulse when DMA mode or the mask was active
   a_r5_irq_quiet: assert property (@(posedge clk) disable iff (rst)
      tx_irq |-> (!$past(dma_en) && !$past(irq_mask)));
   // R4: a full register and an empty shifter never persist together
   a_r4_auto_move: assert property (@(posedge clk) disable iff (rst)
      (full && sh_idle) |=> !full);
endmodule

// File: tb/sertx_chan_test.sv
`timescale 1ns/1ps
module sertx_chan_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sclk_en = 1'b0, frame_start = 1'b0;
   logic [4:0]  slen = 5'd7;
   logic        dma_en = 1'b0, cpu_wr = 1'b0, dma_wr = 1'b0;
   logic [31:0] wdata = '0;
   logic        irq_mask = 1'b0, uf_clr = 1'b0;
   logic        txd, tx_active, full, dma_req, tx_irq, underflow;

   int checks = 0, fails = 0, irq_cnt = 0;
   bit done = 0;
   logic exp_q[$];

   always #2 clk = ~clk;

   sertx_chan uut (
      .clk(clk), .rst(rst), .sclk_en(sclk_en), .frame_start(frame_start),
      .slen(slen), .dma_en(dma_en), .cpu_wr(cpu_wr), .dma_wr(dma_wr),
      .wdata(wdata), .irq_mask(irq_mask), .uf_clr(uf_clr),
      .txd(txd), .tx_active(tx_active), .full(full), .dma_req(dma_req),
      .tx_irq(tx_irq), .underflow(underflow)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // scoreboard monitor: R6/R7 serial stream
   initial begin
      forever begin
         logic stb;
         @(posedge clk);
         stb = sclk_en;
         #1;
         if (!rst && tx_irq) irq_cnt++;
         if (!rst && stb && tx_active) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected bit", int'(txd), -1);
            else begin
               logic e;
               e = exp_q.pop_front();
               chk(txd === e, "R6/R7 serial bit", int'(txd), int'(e));
            end
         end
      end
   end

   task automatic tick(input logic stb, input logic fs);
      @(negedge clk);
      sclk_en = stb; frame_start = fs;
      cpu_wr = 0; dma_wr = 0; uf_clr = 0;
   endtask

   task automatic strobe(input logic fs);
      for (int k = 0; k < 3; k++) tick(0, 0);
      tick(1, fs);
   endtask

   // driver: performs a write and queues expected bits when accepted
   task automatic put(input logic c, input logic d, input logic [31:0] w,
                      input bit accept, input int nbits);
      @(negedge clk);
      sclk_en = 0; frame_start = 0; uf_clr = 0;
      cpu_wr = c; dma_wr = d; wdata = w;
      if (accept)
         for (int b = nbits - 1; b >= 0; b--) exp_q.push_back(w[b]);
   endtask

   task automatic send_frame(input int nbits, input bit mid_fs);
      strobe(1);
      for (int i = 1; i < nbits; i++) strobe(mid_fs && i == 1);
      tick(0, 0);
      chk(tx_active == 1, "R6 active through last bit", int'(tx_active), 1);
      strobe(0);
      tick(0, 0);
      chk(tx_active == 0, "R6 word ends one strobe after bit 0", int'(tx_active), 0);
      chk(txd == 0, "R10 txd low when idle", int'(txd), 0);
   endtask

   initial begin
      #700000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int ic;
      repeat (3) tick(0, 0);
      chk(full == 0 && underflow == 0 && tx_active == 0 && tx_irq == 0 && txd == 0,
          "R1 reset state", int'({full, underflow, tx_active, tx_irq, txd}), 0);
      @(negedge clk); rst = 0;

      // R2 R4 R5: processor write, auto transfer, interrupt
      slen = 5'd7;
      put(1, 0, 32'hABCD_EE5A, 1, 8);
      tick(0, 0);
      chk(full == 1, "R2 cpu write sets full", int'(full), 1);
      tick(0, 0);
      chk(full == 0, "R4 word moved to shifter", int'(full), 0);
      chk(tx_irq == 1, "R5 irq pulse on transfer", int'(tx_irq), 1);
      tick(0, 0);
      chk(tx_irq == 0, "R5 irq single cycle", int'(tx_irq), 0);

      // R3: second word queued, third ignored
      put(1, 0, 32'h0000_00C3, 1, 8);
      put(1, 0, 32'h0000_00FF, 0, 8);
      tick(0, 0);
      chk(full == 1, "R3 two words pending", int'(full), 1);
      chk(dma_req == 0, "R9 no request outside DMA mode", int'(dma_req), 0);
      send_frame(8, 1'b1);           // R6: frame_start mid-word ignored
      tick(0, 0);
      chk(full == 0, "R4 second word transferred", int'(full), 0);
      send_frame(8, 1'b0);
      chk(irq_cnt == 2, "R5 one pulse per transfer", irq_cnt, 2);

      // R3 R8: third write was ignored, so a frame start underflows
      chk(underflow == 0, "R8 no underflow yet", int'(underflow), 0);
      strobe(1);
      tick(0, 0);
      chk(underflow == 1, "R3/R8 underflow after ignored write", int'(underflow), 1);
      chk(tx_active == 0, "R8 nothing sent on underflow", int'(tx_active), 0);
      for (int k = 0; k < 6; k++) tick(0, 0);
      chk(underflow == 1, "R8 flag sticky", int'(underflow), 1);
      @(negedge clk);
      sclk_en = 1; frame_start = 1; uf_clr = 1;
      tick(0, 0);
      chk(underflow == 1, "R8 set wins over clear", int'(underflow), 1);
      @(negedge clk); uf_clr = 1;
      tick(0, 0);
      chk(underflow == 0, "R8 write-one clear", int'(underflow), 0);

      // R5 R7: mask, full 32-bit word
      irq_mask = 1; slen = 5'd31; ic = irq_cnt;
      put(1, 0, 32'h9E37_79B9, 1, 32);
      repeat (3) tick(0, 0);
      chk(irq_cnt == ic, "R5 masked transfer gives no pulse", irq_cnt, ic);
      send_frame(32, 1'b0);
      irq_mask = 0;

      // R7: length code 0 clamps to 3 bits, upper bits dropped
      slen = 5'd0;
      put(1, 0, 32'hFFFF_FFF5, 1, 3);
      repeat (2) tick(0, 0);
      send_frame(3, 1'b0);
      slen = 5'd4;
      put(1, 0, 32'hF0F0_F0F6, 1, 5);
      repeat (2) tick(0, 0);
      send_frame(5, 1'b0);

      // R2 R5 R9: DMA mode
      dma_en = 1; ic = irq_cnt;
      tick(0, 0);
      chk(dma_req == 1, "R9 request when empty", int'(dma_req), 1);
      put(1, 0, 32'h0000_0007, 0, 5);
      tick(0, 0);
      chk(full == 0, "R2 cpu write ignored in DMA mode", int'(full), 0);
      put(0, 1, 32'h0000_0012, 1, 5);
      tick(0, 0);
      chk(full == 1 && dma_req == 0, "R2/R9 DMA write accepted",
          int'({full, dma_req}), 2);
      repeat (3) tick(0, 0);
      chk(irq_cnt == ic, "R5 no pulse in DMA mode", irq_cnt, ic);
      send_frame(5, 1'b0);
      dma_en = 0;
      @(negedge clk); dma_wr = 1; wdata = 32'h1;
      tick(0, 0);
      chk(full == 0, "R2 DMA strobe ignored outside DMA mode", int'(full), 0);

      // R1: reset during shifting
      slen = 5'd15;
      put(1, 0, 32'h0000_A5A5, 1, 16);
      put(1, 0, 32'h0000_1234, 1, 16);
      tick(0, 0);
      strobe(1);
      strobe(0);
      strobe(1);
      tick(0, 0);
      @(negedge clk); rst = 1;
      tick(0, 0);
      chk(full == 0 && tx_active == 0 && txd == 0 && underflow == 0 && tx_irq == 0,
          "R1 reset mid-word", int'({full, tx_active, txd, underflow, tx_irq}), 0);
      exp_q.delete();
      @(negedge clk); rst = 0;
      repeat (8) strobe(0);
      chk(tx_active == 0, "R1 nothing resumes after reset", int'(tx_active), 0);

      chk(exp_q.size() == 0, "R6 all queued bits sent", exp_q.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule